// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This unit applies one of thirteen unary operations to a data value: clear, complement, negate, increment, decrement, test, add carry, subtract carry, arithmetic shift right and left, rotate right and left through carry, and byte swap. The caller supplies the operand, a four-bit operation code, a flag selecting byte or word width, and the current carry. The unit returns the result together with new negative (N), zero (Z), overflow (V) and carry (C) condition codes.

Results and flags are registered, so they appear one clock after the inputs are presented. The data width is a parameter `W` (default 16). A byte is the low half of the word, `H = W/2` bits. In byte mode the sign is taken from bit `H-1` instead of bit `W-1`.

A new operation can be issued every cycle. There is no handshake and no enable: the output registers reload on every clock edge.

Top module: `sop_alu`

## Requirements
- R1: While `rst_n` is low, `result_o` is zero and all four flags are zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. A change on the inputs between edges does not alter the outputs.
- R3: In byte mode (`byte_i`=1, any code except 12), only the low `H` bits are computed, N is result bit `H-1`, and Z tests the low `H` bits only. The upper `H` bits of `result_o` pass through from the operand unchanged.
- R4: Code 0 (clear) yields 0 with Z=1 and N=V=C=0. Code 5 (test) and the unused codes 13 to 15 return the operand, set N and Z from it, and clear V and C.
- R5: Code 1 (complement) returns the bitwise inverse, sets C=1 and clears V.
- R6: Code 2 (negate) returns the two's complement. V=1 only when the result is the most negative value, and C=1 whenever the result is nonzero.
- R7: Code 3 (increment) adds 1 and sets V when the operand was the most positive value. Code 4 (decrement) subtracts 1 and sets V when the operand was the most negative value. Both leave C equal to `carry_i`.
- R8: Code 6 adds `carry_i`. It sets V when the carry is 1 and the operand is the most positive value, and sets C when the carry is 1 and the operand is all ones. Code 7 subtracts `carry_i`. It sets V when the carry is 1 and the operand is the most negative value, and sets C when the carry is 1 and the operand is zero.
- R9: Code 8 shifts right, copying the sign bit into itself, with C taking the bit shifted out of bit 0. Code 9 shifts left with zero fill, with C taking the old sign bit.
- R10: Code 10 rotates right through carry, putting `carry_i` into the sign bit, with C taking old bit 0. Code 11 rotates left through carry, putting `carry_i` into bit 0, with C taking the old sign bit.
- R11: For codes 8 to 11, V equals N XOR C of the new flags.
- R12: Code 12 swaps the high and low halves of the full word, whatever `byte_i` is. N and Z come from the new low half, and V and C are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width |
| carry_i | input | 1 | Current carry flag |
| operand_i | input | W | Source value |
| result_o | output | W | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The bench builds the unit with `W` = 8, which makes the byte half four bits wide. At that size every operand value can be swept against every code, both widths and both carry inputs. The sweep therefore covers every boundary value for each flag rule: most positive, most negative, all ones and zero. It also exercises the pass-through of the upper half in byte mode across all of its patterns, and the byte swap with every combination of halves.

// File: rtl/sop_alu.sv
module sop_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic         carry_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] result_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  localparam int H = W / 2;
  localparam logic [3:0] OP_CLR = 4'd0, OP_COM = 4'd1, OP_NEG = 4'd2, OP_INC = 4'd3,
                         OP_DEC = 4'd4, OP_ADC = 4'd6, OP_SBC = 4'd7,
                         OP_ASR = 4'd8, OP_ASL = 4'd9, OP_ROR = 4'd10, OP_ROL = 4'd11,
                         OP_SWP = 4'd12;
  localparam logic [W-1:0] LOW_MASK = {{(W-H){1'b0}}, {H{1'b1}}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         is_byte;
  logic [W-1:0] mask, signm, tv, r, rv, res;
  logic         msb_in, n, z, v, c;

  assign is_byte = byte_i && (op_i != OP_SWP);
  assign mask    = is_byte ? LOW_MASK : '1;
  assign signm   = is_byte ? (ONE << (H-1)) : (ONE << (W-1));
  assign tv      = operand_i & mask;
  assign msb_in  = |(tv & signm);
  assign rv      = r & mask;

  always_comb begin
    r = tv;
    v = 1'b0;
    c = 1'b0;
    unique case (op_i)
      OP_CLR: r = '0;
      OP_COM: begin r = ~tv; c = 1'b1; end
      OP_NEG: begin
        r = (~tv + ONE) & mask;
        v = (r == signm);
        c = (r != '0);
      end
      OP_INC: begin r = tv + ONE; v = (tv == signm - ONE); c = carry_i; end
      OP_DEC: begin r = tv - ONE; v = (tv == signm);       c = carry_i; end
      OP_ADC: begin
        r = tv + {{(W-1){1'b0}}, carry_i};
        v = carry_i && (tv == signm - ONE);
        c = carry_i && (tv == mask);
      end
      OP_SBC: begin
        r = tv - {{(W-1){1'b0}}, carry_i};
        v = carry_i && (tv == signm);
        c = carry_i && (tv == '0);
      end
      OP_ASR: begin r = (tv >> 1) | (msb_in  ? signm : '0); c = tv[0]; end
      OP_ROR: begin r = (tv >> 1) | (carry_i ? signm : '0); c = tv[0]; end
      OP_ASL: begin r = tv << 1; c = msb_in; end
      OP_ROL: begin r = (tv << 1) | {{(W-1){1'b0}}, carry_i}; c = msb_in; end
      OP_SWP: r = {operand_i[H-1:0], operand_i[W-1:H]};
      default: r = tv;
    endcase
  end

  always_comb begin
    res = is_byte ? ((operand_i & ~mask) | rv) : r;
    if (op_i == OP_SWP) begin
      n = r[H-1];
      z = (r[H-1:0] == '0);
    end else begin
      n = |(rv & signm);
      z = (rv == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      {n_o, z_o, v_o, c_o} <= 4'b0;
    end else begin
      result_o <= res;
      n_o <= n;
      z_o <= z;
      v_o <= (op_i >= OP_ASR && op_i <= OP_ROL) ? (n ^ c) : v;
      c_o <= c;
    end
  end
endmodule

// File: rtl/sop_alu_checker.sv
module sop_alu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic         byte_i,
  input logic         carry_i,
  input logic [W-1:0] operand_i,
  input logic [W-1:0] result_o,
  input logic         n_o,
  input logic         z_o,
  input logic         v_o,
  input logic         c_o
);
  localparam int H = W / 2;
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (result_o == '0 && !n_o && !z_o && !v_o && !c_o));

  p_byte_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live && byte_i && op_i != 4'd12 |=> result_o[W-1:H] == $past(operand_i[W-1:H]));

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_i == 4'd0 |=> (z_o && !n_o && !v_o && !c_o && result_o[H-1:0] == '0));

  p_com_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_i == 4'd1 |=> (c_o && !v_o));

  p_incdec_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live && (op_i == 4'd3 || op_i == 4'd4) |=> c_o == $past(carry_i));

  p_shift_v_r11: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_i >= 4'd8 && op_i <= 4'd11 |=> v_o == (n_o ^ c_o));

  p_swab_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_i == 4'd12 |=> (!v_o && !c_o && result_o == {$past(operand_i[H-1:0]), $past(operand_i[W-1:H])}));
endmodule

bind sop_alu sop_alu_checker #(.W(W)) i_sop_alu_checker (.*);

// File: tb/test_sop_alu.sv
module test_sop_alu;
  localparam int W = 8;
  localparam int H = 4;
  logic clk = 0, rst_n = 0;
  logic [3:0] op_i = 0;
  logic byte_i = 0, carry_i = 0;
  logic [W-1:0] operand_i = 0;
  logic [W-1:0] result_o;
  logic n_o, z_o, v_o, c_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sop_alu #(.W(W)) i_sop_alu (.*);

  function automatic string tag_of(int op);
    case (op)
      0, 5, 13, 14, 15: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4: return "R7";
      6, 7: return "R8";
      8, 9: return "R9";
      10, 11: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d byte %0b cin %0b opd %0h)",
               tag, act, exp, op_i, byte_i, carry_i, operand_i);
    end
  endtask

  task automatic model(input int op, input int bm, input int cin, input int opd,
                       output int full, output int fl);
    int n, md, sg, v, r, vf, cf, nf, zf;
    if (op == 12) begin
      full = (opd % 16) * 16 + opd / 16;
      nf = (opd / 16) >= 8; zf = (opd / 16) == 0;
      fl = nf * 8 + zf * 4;
      return;
    end
    n = bm ? H : W; md = 1 << n; sg = 1 << (n - 1); v = opd % md;
    vf = 0; cf = 0;
    case (op)
      0: r = 0;
      1: begin r = md - 1 - v; cf = 1; end
      2: begin r = (md - v) % md; vf = (r == sg); cf = (r != 0); end
      3: begin r = (v + 1) % md; vf = (v == sg - 1); cf = cin; end
      4: begin r = (v + md - 1) % md; vf = (v == sg); cf = cin; end
      6: begin r = (v + cin) % md; vf = cin && v == sg - 1; cf = cin && v == md - 1; end
      7: begin r = (v + md - cin) % md; vf = cin && v == sg; cf = cin && v == 0; end
      8: begin r = v / 2 + ((v >= sg) ? sg : 0); cf = v % 2; end
      9: begin r = (v * 2) % md; cf = v >= sg; end
      10: begin r = v / 2 + cin * sg; cf = v % 2; end
      11: begin r = (v * 2) % md + cin; cf = v >= sg; end
      default: r = v;
    endcase
    nf = r >= sg; zf = r == 0;
    if (op >= 8 && op <= 11) vf = nf ^ cf;   // R11
    full = bm ? (opd / md) * md + r : r;
    fl = nf * 8 + zf * 4 + vf * 2 + cf;
  endtask

  initial begin
    int full, fl;
    @(negedge clk);
    check("R1", {n_o, z_o, v_o, c_o, result_o}, 0);
    @(negedge clk); rst_n = 1;
    for (int op = 0; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int cin = 0; cin < 2; cin++)
          for (int d = 0; d < 256; d++) begin
            op_i = op[3:0]; byte_i = bm[0]; carry_i = cin[0]; operand_i = d[7:0];
            @(negedge clk);
            model(op, bm, cin, d, full, fl);
            check(tag_of(op), {n_o, z_o, v_o, c_o, result_o}, fl * 256 + full);
            if (bm == 1 && op != 12) check("R3", int'(result_o[W-1:H]), d / 16);
            if (d == 77) begin
              operand_i = ~operand_i; op_i = 4'd1;
              #1 check("R2", {n_o, z_o, v_o, c_o, result_o}, fl * 256 + full);
            end
          end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++; $display("FAIL watchdog: actual timeout expected finish"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule